// File: doc/BRIEF.md
# Dual-Register Timer Capture/Compare Unit

This block is a 16-bit up-counter paired with two 16-bit registers. Each register works either as a compare register, which raises an interrupt pulse when the counter reaches its value, or as a capture register, which stores the running count when a chosen edge appears on an external input pin. Register 0's compare match can also reload the counter to zero, which turns the counter into an interval timer with a programmable period.

Two asynchronous input pins pass through a two-flop synchroniser and an edge detector. Each pin has a 2-bit edge code. Pin A drives both registers, but register 0 reacts to the edge opposite to the one selected. Register 1 reacts to the selected edge itself. Register 0 can instead take its trigger from pin B, where it follows that pin's selected edge directly. Software writes and reads the registers over a small synchronous bus. A flag tells the pin logic outside the block to keep the shared toggle output off while pin A is in use as a capture source.

Top module: `cc_timer_top`

## Requirements
- R1: After reset the counter, both registers, `irq0`, `irq1` and `overflow` are all zero.
- R2: While `timerEn` is low, the counter holds 0. While it is high, the counter rises by one on each clock edge, so it reads k after k edges from enable.
- R3: `overflow` is high for exactly one cycle: the cycle in which the counter reads 0 after it has read FFFFH.
- R4: With register 0 in compare mode (`reg0Capture`=0), `irq0` is high for one cycle, in the cycle after the counter has advanced into the value of register 0. Bus address 0 writes register 0, address 1 writes register 1, and address 2 reads the counter.
- R5: With `clearOnMatch`=1, the counter reads 0 in the same cycle in which `irq0` rises, so a compare value N gives one `irq0` every N+1 cycles.
- R6: In free-running mode with compare value 0000H, `irq0` rises one cycle after the `overflow` pulse.
- R7: If register 0 is rewritten to a value below the current count, no `irq0` occurs until the counter has wrapped through FFFFH.
- R8: Edge codes are 00 = falling, 01 = rising, 10 = no edge, 11 = both edges. Register 1 in capture mode stores, on the edge selected for pin A, the counter value shown two clock edges after the pin change is first sampled. The value is readable and `irq1` pulses one edge later.
- R9: With pin A as its source, register 0 captures on the edge opposite to the one selected for pin A (code 01 means capture on falling, code 00 means capture on rising). With code 11 it never captures.
- R10: With `reg0FromPinB`=1, register 0 captures on exactly the edge selected for pin B, with the same timing as R8.
- R11: Code 10 on a pin causes no capture and no interrupt in any register fed by that pin.
- R12: `toggleOutOff` is high exactly when register 1 is in capture mode, or when register 0 is in capture mode with pin A as its source.
- R13: Register 1 in compare mode pulses `irq1` one cycle after the counter advances into its value, and it never clears the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address (0 = register 0, 1 = register 1) |
| wrData | input | 16 | Write data |
| rdAddr | input | 2 | Read address (0, 1 registers; 2 counter; 3 reads zero) |
| rdData | output | 16 | Combinational read data |
| timerEn | input | 1 | Counter run enable |
| clearOnMatch | input | 1 | 1 = reload counter on register 0 match |
| reg0Capture | input | 1 | 1 = register 0 is a capture register |
| reg1Capture | input | 1 | 1 = register 1 is a capture register |
| reg0FromPinB | input | 1 | 1 = register 0 capture trigger is pin B |
| edgeSelA | input | 2 | Edge code for pin A |
| edgeSelB | input | 2 | Edge code for pin B |
| pinA | input | 1 | Asynchronous capture input A |
| pinB | input | 1 | Asynchronous capture input B |
| irq0 | output | 1 | Register 0 match/capture pulse |
| irq1 | output | 1 | Register 1 match/capture pulse |
| overflow | output | 1 | One-cycle wrap flag |
| toggleOutOff | output | 1 | Force shared toggle output inactive |

## Verification
A wrong match qualifier or counter state shows up as an interrupt in the wrong cycle. The interval between two `irq0` pulses in clear mode exposes it within one period, and a stale compare value shows it within one full wrap of 65536 cycles. A fault in the edge decode shows up as the wrong register changing, or as a missing `irq0` or `irq1` pulse. Both are seen three edges after the pin toggles. A capture that takes the count one cycle early or late reads back off by one.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_REG0 = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_REG1 = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd2;

  // edge select encodings
  localparam logic [1:0] EDGE_FALL = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_NONE = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;

  typedef struct packed {
    logic run;
    logic clrOnMatch;
    logic cmp0En;
    logic cmp1En;
    logic cap0;
    logic cap1;
  } ctrl_strobes_t;

  // selected edge seen
  function automatic logic edgeHit(input logic [1:0] code, input logic rise, input logic fall);
    case (code)
      EDGE_FALL: edgeHit = fall;
      EDGE_RISE: edgeHit = rise;
      EDGE_BOTH: edgeHit = rise | fall;
      default:   edgeHit = 1'b0;
    endcase
  endfunction

  // opposite of the selected edge; none when both or prohibited
  function automatic logic edgeOpposite(input logic [1:0] code, input logic rise, input logic fall);
    case (code)
      EDGE_FALL: edgeOpposite = rise;
      EDGE_RISE: edgeOpposite = fall;
      default:   edgeOpposite = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cc_edge_detect.sv
module cc_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chainQ;

  always_ff @(posedge clk) begin
    if (!rstN) chainQ <= '0;
    else       chainQ <= {chainQ[STAGES-1:0], pinIn};
  end

  logic syncVal;
  logic prevVal;
  assign syncVal = chainQ[STAGES-1];
  assign prevVal = chainQ[STAGES];
  assign rise = syncVal & ~prevVal;
  assign fall = ~syncVal & prevVal;

  // edge pulses are mutually exclusive
  single_edge_chk: assert property (@(posedge clk) disable iff (!rstN) !(rise && fall));
endmodule

// File: rtl/cc_timer_ctrl.sv
module cc_timer_ctrl
  import cc_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          timerEn,
  input  logic          clearOnMatch,
  input  logic          reg0Capture,
  input  logic          reg1Capture,
  input  logic          reg0FromPinB,
  input  logic [1:0]    edgeSelA,
  input  logic [1:0]    edgeSelB,
  input  logic          pinA,
  input  logic          pinB,
  output ctrl_strobes_t strobes,
  output logic          toggleOutOff
);
  localparam int NUM_PINS = 2;

  logic [NUM_PINS-1:0] pinVec;
  logic [NUM_PINS-1:0] riseVec;
  logic [NUM_PINS-1:0] fallVec;

  assign pinVec = {pinB, pinA};

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    cc_edge_detect #(.STAGES(SYNC_STAGES)) u_det (
      .clk  (clk),
      .rstN (rstN),
      .pinIn(pinVec[p]),
      .rise (riseVec[p]),
      .fall (fallVec[p])
    );
  end

  logic cap0FromA;
  logic cap0FromB;
  logic cap1FromA;

  assign cap0FromA = edgeOpposite(edgeSelA, riseVec[0], fallVec[0]);
  assign cap0FromB = edgeHit(edgeSelB, riseVec[1], fallVec[1]);
  assign cap1FromA = edgeHit(edgeSelA, riseVec[0], fallVec[0]);

  always_comb begin
    strobes.run        = timerEn;
    strobes.clrOnMatch = clearOnMatch;
    strobes.cmp0En     = timerEn & ~reg0Capture;
    strobes.cmp1En     = timerEn & ~reg1Capture;
    strobes.cap0       = reg0Capture & (reg0FromPinB ? cap0FromB : cap0FromA);
    strobes.cap1       = reg1Capture & cap1FromA;
  end

  assign toggleOutOff = reg1Capture | (reg0Capture & ~reg0FromPinB);

  // R9
  both_edge_no_cap0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!reg0FromPinB && edgeSelA == EDGE_BOTH && (riseVec[0] || fallVec[0])) |-> !strobes.cap0);

  // R11
  prohibited_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (edgeSelA == EDGE_NONE && (riseVec[0] || fallVec[0])) |-> !strobes.cap1);
endmodule

// File: rtl/cc_timer_datapath.sv
module cc_timer_datapath
  import cc_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobes_t     strobes,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic              irq0,
  output logic              irq1,
  output logic              overflow
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] reg0Q;
  logic [CNT_W-1:0] reg1Q;
  logic             movedQ;
  logic             match0;
  logic             match1;

  // a match only counts on a value the counter has advanced into
  assign match0 = strobes.cmp0En & movedQ & (cntQ == reg0Q);
  assign match1 = strobes.cmp1En & movedQ & (cntQ == reg1Q);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ     <= '0;
      movedQ   <= 1'b0;
      overflow <= 1'b0;
    end else begin
      movedQ   <= strobes.run;
      overflow <= strobes.run & (cntQ == CNT_MAX);
      if (!strobes.run)
        cntQ <= '0;
      else if (strobes.clrOnMatch && match0)
        cntQ <= '0;
      else
        cntQ <= cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reg0Q <= '0;
      reg1Q <= '0;
      irq0  <= 1'b0;
      irq1  <= 1'b0;
    end else begin
      irq0 <= match0 | strobes.cap0;
      irq1 <= match1 | strobes.cap1;
      if (strobes.cap0)
        reg0Q <= cntQ;
      else if (wrEn && wrAddr == ADDR_REG0)
        reg0Q <= wrData;
      if (strobes.cap1)
        reg1Q <= cntQ;
      else if (wrEn && wrAddr == ADDR_REG1)
        reg1Q <= wrData;
    end
  end

  always_comb begin
    case (rdAddr)
      ADDR_REG0: rdData = reg0Q;
      ADDR_REG1: rdData = reg1Q;
      ADDR_CNT:  rdData = cntQ;
      default:   rdData = '0;
    endcase
  end

  // R2
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.run |=> (cntQ == '0));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (cntQ == '0));

  // R5
  clear_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq0 && $past(strobes.clrOnMatch) && $past(strobes.cmp0En)) |-> (cntQ == '0));

  // R8
  cap1_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.cap1) |-> (reg1Q == $past(cntQ)));
endmodule

// File: rtl/cc_timer_top.sv
module cc_timer_top
  import cc_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [1:0]        rdAddr,
  output logic [CNT_W-1:0]  rdData,
  input  logic              timerEn,
  input  logic              clearOnMatch,
  input  logic              reg0Capture,
  input  logic              reg1Capture,
  input  logic              reg0FromPinB,
  input  logic [1:0]        edgeSelA,
  input  logic [1:0]        edgeSelB,
  input  logic              pinA,
  input  logic              pinB,
  output logic              irq0,
  output logic              irq1,
  output logic              overflow,
  output logic              toggleOutOff
);
  ctrl_strobes_t strobes;

  cc_timer_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .timerEn     (timerEn),
    .clearOnMatch(clearOnMatch),
    .reg0Capture (reg0Capture),
    .reg1Capture (reg1Capture),
    .reg0FromPinB(reg0FromPinB),
    .edgeSelA    (edgeSelA),
    .edgeSelB    (edgeSelB),
    .pinA        (pinA),
    .pinB        (pinB),
    .strobes     (strobes),
    .toggleOutOff(toggleOutOff)
  );

  cc_timer_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .irq0    (irq0),
    .irq1    (irq1),
    .overflow(overflow)
  );

  // R12
  toggle_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    reg1Capture |-> toggleOutOff);
endmodule

// File: tb/tb_cc_timer_top.sv
module tb_cc_timer_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        timerEn = 1'b0;
  logic        clearOnMatch = 1'b0;
  logic        reg0Capture = 1'b0;
  logic        reg1Capture = 1'b0;
  logic        reg0FromPinB = 1'b0;
  logic [1:0]  edgeSelA = 2'b01;
  logic [1:0]  edgeSelB = 2'b01;
  logic        pinA = 1'b0;
  logic        pinB = 1'b0;
  logic        irq0, irq1, overflow, toggleOutOff;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cc_timer_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .timerEn(timerEn), .clearOnMatch(clearOnMatch),
    .reg0Capture(reg0Capture), .reg1Capture(reg1Capture), .reg0FromPinB(reg0FromPinB),
    .edgeSelA(edgeSelA), .edgeSelB(edgeSelB), .pinA(pinA), .pinB(pinB),
    .irq0(irq0), .irq1(irq1), .overflow(overflow), .toggleOutOff(toggleOutOff)
  );

  // compare-mode vectors: value, clear mode, edges to first irq0, edges between irq0 (0 = skip)
  localparam int NV = 5;
  localparam logic [15:0] TBL_CMP   [NV] = '{16'd5, 16'd1, 16'd40, 16'd200, 16'd3};
  localparam bit          TBL_CLR   [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam int          TBL_FIRST [NV] = '{6, 2, 41, 201, 4};
  localparam int          TBL_GAP   [NV] = '{6, 2, 0, 201, 0};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [15:0] d);
    rdAddr = a;
    #0.5;
    d = rdData;
  endtask

  // toggle a pin at a negedge; return counter seen while the edge is detected;
  // returns at the negedge where the captured value and irq are visible
  task automatic pinEvent(input bit useB, input logic lvl, output logic [15:0] expCnt);
    @(negedge clk);
    if (useB) pinB = lvl; else pinA = lvl;
    @(negedge clk);
    @(negedge clk);
    rdReg(2'd2, expCnt);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, ec;
    int lat, hits;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rdReg(2'd2, v); check(v == 0, "R1 counter", v, 0);
    rdReg(2'd0, v); check(v == 0, "R1 reg0", v, 0);
    rdReg(2'd1, v); check(v == 0, "R1 reg1", v, 0);
    check(!irq0 && !irq1 && !overflow, "R1 outputs", {irq0, irq1, overflow}, 0);

    // R2 hold while disabled, count when enabled
    repeat (4) @(negedge clk);
    rdReg(2'd2, v); check(v == 0, "R2 held", v, 0);
    timerEn = 1'b1;
    repeat (5) @(negedge clk);
    rdReg(2'd2, v); check(v == 5, "R2 count", v, 5);
    timerEn = 1'b0;
    @(negedge clk);

    // R4 R5 vector table
    for (int i = 0; i < NV; i++) begin
      timerEn = 1'b0;
      reg0Capture = 1'b0;
      clearOnMatch = TBL_CLR[i];
      wrReg(2'd0, TBL_CMP[i]);
      @(negedge clk);
      timerEn = 1'b1;
      lat = 0;
      do begin @(negedge clk); lat++; end while (!irq0 && lat < 1000);
      check(lat == TBL_FIRST[i], "R4 first irq0 latency", lat, TBL_FIRST[i]);
      if (TBL_CLR[i]) begin
        rdReg(2'd2, v); check(v == 0, "R5 reload on match", v, 0);
      end
      if (TBL_GAP[i] != 0) begin
        lat = 0;
        do begin @(negedge clk); lat++; end while (!irq0 && lat < 1000);
        check(lat == TBL_GAP[i], "R5 period", lat, TBL_GAP[i]);
      end
    end

    // R13 register 1 compare does not clear
    timerEn = 1'b0;
    reg0Capture = 1'b1;
    clearOnMatch = 1'b1;
    wrReg(2'd1, 16'd30);
    @(negedge clk);
    timerEn = 1'b1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!irq1 && lat < 1000);
    check(lat == 31, "R13 irq1 latency", lat, 31);
    rdReg(2'd2, v); check(v == 31, "R13 no clear", v, 31);

    // R3 R6 R7 free run with compare rewritten below count
    timerEn = 1'b0;
    reg0Capture = 1'b0;
    clearOnMatch = 1'b0;
    wrReg(2'd0, 16'd1000);
    @(negedge clk);
    timerEn = 1'b1;
    lat = 0;
    hits = 0;
    while (lat < 70000) begin
      @(negedge clk);
      lat++;
      if (lat == 2000) begin wrEn = 1'b1; wrAddr = 2'd0; wrData = 16'd0; end
      if (lat == 2001) wrEn = 1'b0;
      if (lat == 1001) check(irq0 == 1'b1, "R4 free-running match", irq0, 1);
      if (lat > 1001 && irq0) hits++;
      if (overflow) break;
    end
    check(lat == 65536, "R3 overflow cycle", lat, 65536);
    check(hits == 0, "R7 no early match", hits, 0);
    rdReg(2'd2, v); check(v == 0, "R3 counter at overflow", v, 0);
    check(irq0 == 1'b0, "R6 irq0 not with overflow", irq0, 0);
    @(negedge clk);
    check(irq0 == 1'b1, "R6 irq0 after wrap", irq0, 1);
    check(overflow == 1'b0, "R3 one-cycle overflow", overflow, 0);

    // capture tests, free-running counter
    clearOnMatch = 1'b0;
    reg0Capture = 1'b1;
    reg1Capture = 1'b1;
    reg0FromPinB = 1'b0;
    edgeSelA = 2'b01;
    @(negedge clk);
    #0.5;
    check(toggleOutOff == 1'b1, "R12 pin A in use", toggleOutOff, 1);
    wrReg(2'd0, 16'hAAAA);
    wrReg(2'd1, 16'h5555);
    pinEvent(1'b0, 1'b1, ec);
    rdReg(2'd1, v); check(v == ec, "R8 reg1 rising capture", v, ec);
    check(irq1 == 1'b1, "R8 irq1 on capture", irq1, 1);
    rdReg(2'd0, v); check(v == 16'hAAAA, "R9 reg0 ignores selected edge", v, 16'hAAAA);
    check(irq0 == 1'b0, "R9 no irq0 on selected edge", irq0, 0);
    pinEvent(1'b0, 1'b0, ec);
    rdReg(2'd0, v); check(v == ec, "R9 reg0 opposite edge", v, ec);
    check(irq0 == 1'b1, "R9 irq0 on opposite edge", irq0, 1);
    check(irq1 == 1'b0, "R8 no irq1 on falling", irq1, 0);

    // R9 both edges
    edgeSelA = 2'b11;
    wrReg(2'd0, 16'hAAAA);
    pinEvent(1'b0, 1'b1, ec);
    rdReg(2'd1, v); check(v == ec, "R9 reg1 both rising", v, ec);
    pinEvent(1'b0, 1'b0, ec);
    rdReg(2'd1, v); check(v == ec, "R9 reg1 both falling", v, ec);
    rdReg(2'd0, v); check(v == 16'hAAAA, "R9 reg0 no capture on both", v, 16'hAAAA);
    check(irq0 == 1'b0, "R9 no irq0 on both", irq0, 0);

    // R11 prohibited code
    edgeSelA = 2'b10;
    wrReg(2'd0, 16'h1234);
    wrReg(2'd1, 16'h4321);
    pinEvent(1'b0, 1'b1, ec);
    check(irq0 == 1'b0 && irq1 == 1'b0, "R11 no irq on rise", {irq0, irq1}, 0);
    pinEvent(1'b0, 1'b0, ec);
    check(irq0 == 1'b0 && irq1 == 1'b0, "R11 no irq on fall", {irq0, irq1}, 0);
    rdReg(2'd0, v); check(v == 16'h1234, "R11 reg0 kept", v, 16'h1234);
    rdReg(2'd1, v); check(v == 16'h4321, "R11 reg1 kept", v, 16'h4321);

    // R10 pin B, falling selected
    reg1Capture = 1'b0;
    reg0FromPinB = 1'b1;
    edgeSelB = 2'b00;
    @(negedge clk);
    #0.5;
    check(toggleOutOff == 1'b0, "R12 pin A free", toggleOutOff, 0);
    wrReg(2'd0, 16'h0BAD);
    pinEvent(1'b1, 1'b1, ec);
    rdReg(2'd0, v); check(v == 16'h0BAD, "R10 reg0 ignores rise on pin B", v, 16'h0BAD);
    pinEvent(1'b1, 1'b0, ec);
    rdReg(2'd0, v); check(v == ec, "R10 reg0 fall on pin B", v, ec);
    check(irq0 == 1'b1, "R10 irq0 on pin B", irq0, 1);
    edgeSelB = 2'b01;
    pinEvent(1'b1, 1'b1, ec);
    rdReg(2'd0, v); check(v == ec, "R10 reg0 rise on pin B", v, ec);

    reg0Capture = 1'b0;
    reg0FromPinB = 1'b0;
    #0.5;
    check(toggleOutOff == 1'b0, "R12 no capture", toggleOutOff, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule